// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block runs one register-to-register add across many register-file elements. A single command gives it the following: an element count, a sub-element group size, a scalar-or-vector flag for the destination and for each source, three base register numbers, and a predicate description. The block then steps through the elements in order. For each sub-element that the predicate enables, it makes two reads and one write against an external register file. The value written is the sum of the two values read. A one-cycle `done` pulse marks the end of the command.

The block covers several cases with one loop, chosen by the operand flags and the predicate:

- **Plain predicated vector add:** all three operands are vectors.
- **Single scalar add:** all three operands are scalar.
- **Broadcast:** scalar sources, vector destination and a full predicate.
- **Insert one element:** scalar sources, vector destination and a single-bit predicate.
- **Pick the first enabled element:** a scalar destination.

The command enters through a valid/ready handshake. `cmd_ready` is high only while the sequencer is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and all `cmd_*` fields are sampled at that edge. While a command is running, `cmd_ready` stays low and a waiting command simply holds `cmd_valid`. The register-file side is a plain port:
- Read addresses are combinational outputs.
- Read data must return in the same cycle.
- Writes cannot be stalled.

Top module: `svl_vec_seq`

## Requirements
- R1: After reset `cmd_ready` is 1 and `done` and `wr_en` are 0. `cmd_ready` is 1 exactly when no command is running, and `wr_en` is never 1 while `cmd_ready` is 1.
- R2: For each element i from 0 to VL-1 in increasing order:
  - If element i is enabled, the block spends SUBVL cycles on it and writes sub-elements s = 0 to SUBVL-1 in order, one write per cycle.
  - If element i is disabled, the block spends one cycle on it and makes no write.
- R3: Each operand's register address is (base + idx*SUBVL + s) mod NREG, where idx is that operand's running element index.
- R4: An operand's idx starts at 0 and increases by one after every element, enabled or not, but only if that operand is marked vector. A scalar operand keeps idx 0.
- R5: Predicate bit i enables all SUBVL sub-elements of element i. Predicate bits at positions VL and above are ignored.
- R6: `cmd_pred_mode` selects the predicate:
  - 0 or 3: element i takes `cmd_pred_mask` bit i.
  - 1: all elements are enabled.
  - 2: only element `cmd_pred_sel` is enabled (a one shifted left by `cmd_pred_sel`).
- R7: With a scalar destination, the command ends right after the last sub-element write of the first enabled element.
- R8: The write data is (rs1_data + rs2_data) mod 2^XLEN, taken from the read data in the same cycle as the write.
- R9: A disabled element causes no write, so its destination registers keep their old values. No writes other than those in R2 occur.
- R10: `done` is high for one cycle, in the cycle after the last sequencing cycle. If VL is 0 or no element is enabled, `done` is high in the cycle after acceptance and no write occurs. In all cases, `done` comes exactly N cycles after the acceptance edge, where N is the number of sequencing cycles given by R2 and R7.
- R11: A VL above MAXVL is treated as MAXVL. A SUBVL of 0 is treated as 1, and a SUBVL above MAXSUBVL is treated as MAXSUBVL.
- R12: In the cycle where `done` is high, `cmd_ready` is also high, so a waiting command is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The sequencer is idle and takes the command |
| cmd_vl | input | 4 | Element count VL |
| cmd_subvl | input | 3 | Sub-element group size SUBVL |
| cmd_rd_vec | input | 1 | Destination is a vector (1) or a scalar (0) |
| cmd_rs1_vec | input | 1 | Source 1 is a vector |
| cmd_rs2_vec | input | 1 | Source 2 is a vector |
| cmd_rd_base | input | 5 | Destination base register |
| cmd_rs1_base | input | 5 | Source 1 base register |
| cmd_rs2_base | input | 5 | Source 2 base register |
| cmd_pred_mode | input | 2 | Predicate mode (0/3 mask, 1 all, 2 single bit) |
| cmd_pred_sel | input | 3 | Bit position for the single-bit mode |
| cmd_pred_mask | input | 8 | Explicit predicate mask |
| rs1_addr | output | 5 | Source 1 read address |
| rs2_addr | output | 5 | Source 2 read address |
| rs1_data | input | 16 | Source 1 read data, same cycle |
| rs2_data | input | 16 | Source 2 read data, same cycle |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 5 | Register write address |
| wr_data | output | 16 | Register write data |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
The end-of-command pulse of one command and the acceptance of the next can fall in the same cycle. The bench provokes this by holding a second command valid while the first one runs. In the cycle where `cmd_ready` rises, it checks that `done` is also high. It then checks that the second command, an empty one, gives its own `done` in the very next cycle, with no writes between the two. Every other command is judged against a reference loop that the bench computes from the requirements alone. The reference covers the write order, the addresses, the sums, the cycle count and the final register-file contents.

// File: rtl/svl_pkg.sv
package svl_pkg;

  typedef enum logic [1:0] {
    PM_MASK     = 2'd0,
    PM_ALL      = 2'd1,
    PM_ONE      = 2'd2,
    PM_MASK_ALT = 2'd3
  } pred_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  localparam int unsigned N_OPND = 3;
  localparam int unsigned OP_RD  = 0;
  localparam int unsigned OP_RS1 = 1;
  localparam int unsigned OP_RS2 = 2;

endpackage

// File: rtl/svl_pred_gen.sv
module svl_pred_gen #(
  parameter int MAXVL = 8,
  parameter int IW    = 3,
  parameter int VLW   = 4
) (
  input  logic [1:0]       mode,
  input  logic [IW-1:0]    sel,
  input  logic [MAXVL-1:0] mask,
  input  logic [VLW-1:0]   vl,
  output logic [MAXVL-1:0] pred
);
  import svl_pkg::*;

  logic [MAXVL-1:0] raw;

  always_comb begin
    unique case (pred_mode_e'(mode))
      PM_ALL:  raw = '1;
      PM_ONE:  raw = MAXVL'(1) << sel;
      default: raw = mask;
    endcase
  end

  // Bits at or beyond the element count never enable anything.
  for (genvar k = 0; k < MAXVL; k++) begin : g_clip
    assign pred[k] = raw[k] & (vl > VLW'(k));
  end

endmodule

// File: rtl/svl_opnd_idx.sv
module svl_opnd_idx #(
  parameter int AW  = 5,
  parameter int IW  = 3,
  parameter int SVW = 3,
  parameter int SW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [AW-1:0]  base_in,
  input  logic           vec_in,
  input  logic           step,
  input  logic [SW-1:0]  sub,
  input  logic [SVW-1:0] subvl,
  output logic [AW-1:0]  addr,
  output logic           is_vec
);
  localparam int WW = AW + IW + SVW + 1;

  logic [AW-1:0] base_q;
  logic          vec_q;
  logic [IW-1:0] idx_q;
  logic [WW-1:0] wide;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      vec_q  <= 1'b0;
      idx_q  <= '0;
    end else if (load) begin
      base_q <= base_in;
      vec_q  <= vec_in;
      idx_q  <= '0;
    end else if (step && vec_q) begin
      idx_q <= idx_q + IW'(1);
    end
  end

  assign wide   = WW'(base_q) + WW'(idx_q) * WW'(subvl) + WW'(sub);
  assign addr   = wide[AW-1:0];
  assign is_vec = vec_q;

endmodule

// File: rtl/svl_elem_add.sv
module svl_elem_add #(
  parameter int XLEN = 16
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] sum
);
  assign sum = a + b;
endmodule

// File: rtl/svl_vec_seq.sv
module svl_vec_seq #(
  parameter  int XLEN     = 16,
  parameter  int NREG     = 32,
  parameter  int MAXVL    = 8,
  parameter  int MAXSUBVL = 4,
  localparam int AW       = $clog2(NREG),
  localparam int VLW      = $clog2(MAXVL + 1),
  localparam int SVW      = $clog2(MAXSUBVL + 1),
  localparam int IW       = $clog2(MAXVL),
  localparam int SW       = $clog2(MAXSUBVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [VLW-1:0]   cmd_vl,
  input  logic [SVW-1:0]   cmd_subvl,
  input  logic             cmd_rd_vec,
  input  logic             cmd_rs1_vec,
  input  logic             cmd_rs2_vec,
  input  logic [AW-1:0]    cmd_rd_base,
  input  logic [AW-1:0]    cmd_rs1_base,
  input  logic [AW-1:0]    cmd_rs2_base,
  input  logic [1:0]       cmd_pred_mode,
  input  logic [IW-1:0]    cmd_pred_sel,
  input  logic [MAXVL-1:0] cmd_pred_mask,
  output logic [AW-1:0]    rs1_addr,
  output logic [AW-1:0]    rs2_addr,
  input  logic [XLEN-1:0]  rs1_data,
  input  logic [XLEN-1:0]  rs2_data,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [XLEN-1:0]  wr_data,
  output logic             done
);
  import svl_pkg::*;

  seq_state_e       state;
  logic [IW-1:0]    i_q;
  logic [SW-1:0]    s_q;
  logic [VLW-1:0]   vl_q;
  logic [SVW-1:0]   subvl_q;
  logic [MAXVL-1:0] mask_q;
  logic             done_q;

  logic             accept;
  logic [VLW-1:0]   vl_c;
  logic [SVW-1:0]   subvl_c;
  logic [MAXVL-1:0] pred_new;

  logic             busy, elem_en, last_sub, last_elem;
  logic             outer_step, finish;
  logic             rs1_scalar;

  logic [AW-1:0]    op_base [N_OPND];
  logic             op_vin  [N_OPND];
  logic [AW-1:0]    op_addr [N_OPND];
  logic             op_vec  [N_OPND];

  // Command-edge normalisation of out-of-range lengths.
  assign vl_c = (cmd_vl > VLW'(MAXVL)) ? VLW'(MAXVL) : cmd_vl;

  always_comb begin
    if (cmd_subvl == '0)                 subvl_c = SVW'(1);
    else if (cmd_subvl > SVW'(MAXSUBVL)) subvl_c = SVW'(MAXSUBVL);
    else                                 subvl_c = cmd_subvl;
  end

  svl_pred_gen #(.MAXVL(MAXVL), .IW(IW), .VLW(VLW)) u_pred (
    .mode (cmd_pred_mode),
    .sel  (cmd_pred_sel),
    .mask (cmd_pred_mask),
    .vl   (vl_c),
    .pred (pred_new)
  );

  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign busy      = (state == ST_RUN);

  // Loop control: the predicate is indexed by the outer element only.
  assign elem_en    = mask_q[i_q];
  assign last_sub   = (SVW'(s_q) == subvl_q - SVW'(1));
  assign last_elem  = (VLW'(i_q) == vl_q - VLW'(1));
  assign outer_step = busy && (!elem_en || last_sub);
  assign finish     = outer_step && (last_elem || (elem_en && !op_vec[OP_RD]));

  assign op_base[OP_RD]  = cmd_rd_base;
  assign op_base[OP_RS1] = cmd_rs1_base;
  assign op_base[OP_RS2] = cmd_rs2_base;
  assign op_vin[OP_RD]   = cmd_rd_vec;
  assign op_vin[OP_RS1]  = cmd_rs1_vec;
  assign op_vin[OP_RS2]  = cmd_rs2_vec;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    svl_opnd_idx #(.AW(AW), .IW(IW), .SVW(SVW), .SW(SW)) u_idx (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .base_in (op_base[g]),
      .vec_in  (op_vin[g]),
      .step    (outer_step),
      .sub     (s_q),
      .subvl   (subvl_q),
      .addr    (op_addr[g]),
      .is_vec  (op_vec[g])
    );
  end

  svl_elem_add #(.XLEN(XLEN)) u_add (
    .a   (rs1_data),
    .b   (rs2_data),
    .sum (wr_data)
  );

  assign rs1_addr   = op_addr[OP_RS1];
  assign rs2_addr   = op_addr[OP_RS2];
  assign wr_addr    = op_addr[OP_RD];
  assign wr_en      = busy && elem_en;
  assign done       = done_q;
  assign rs1_scalar = !op_vec[OP_RS1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      i_q     <= '0;
      s_q     <= '0;
      vl_q    <= '0;
      subvl_q <= SVW'(1);
      mask_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            vl_q    <= vl_c;
            subvl_q <= subvl_c;
            mask_q  <= pred_new;
            i_q     <= '0;
            s_q     <= '0;
            if (pred_new == '0) done_q <= 1'b1;
            else                state  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (outer_step) begin
            i_q <= i_q + IW'(1);
            s_q <= '0;
            if (finish) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end
          end else begin
            s_q <= s_q + SW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/svl_vec_seq_chk.sv
module svl_vec_seq_chk #(
  parameter int AW    = 5,
  parameter int VLW   = 4,
  parameter int SVW   = 3,
  parameter int MAXVL = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [VLW-1:0]   cmd_vl,
  input logic [1:0]       cmd_pred_mode,
  input logic [MAXVL-1:0] cmd_pred_mask,
  input logic             wr_en,
  input logic             done,
  input logic [AW-1:0]    rs1_addr,
  input logic             rs1_scalar,
  input logic [SVW-1:0]   subvl_q
);

  p_no_write_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !cmd_ready);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

  p_empty_vl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_vl == '0) |=> (done && cmd_ready));

  p_empty_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_pred_mode == 2'd0 || cmd_pred_mode == 2'd3)
     && cmd_pred_mask == '0) |=> (done && cmd_ready));

  p_scalar_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && $past(!cmd_ready) && rs1_scalar && subvl_q == SVW'(1))
    |-> $stable(rs1_addr));

  p_ready_at_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

endmodule

bind svl_vec_seq svl_vec_seq_chk #(.AW(AW), .VLW(VLW), .SVW(SVW), .MAXVL(MAXVL)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_vl        (cmd_vl),
  .cmd_pred_mode (cmd_pred_mode),
  .cmd_pred_mask (cmd_pred_mask),
  .wr_en         (wr_en),
  .done          (done),
  .rs1_addr      (rs1_addr),
  .rs1_scalar    (rs1_scalar),
  .subvl_q       (subvl_q)
);

// File: tb/svl_vec_seq_bench.sv
module svl_vec_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_vl = '0;
  logic [2:0]  cmd_subvl = 3'd1;
  logic        cmd_rd_vec = 1'b0, cmd_rs1_vec = 1'b0, cmd_rs2_vec = 1'b0;
  logic [4:0]  cmd_rd_base = '0, cmd_rs1_base = '0, cmd_rs2_base = '0;
  logic [1:0]  cmd_pred_mode = '0;
  logic [2:0]  cmd_pred_sel = '0;
  logic [7:0]  cmd_pred_mask = '0;
  logic [4:0]  rs1_addr, rs2_addr, wr_addr;
  logic [15:0] rs1_data, rs2_data, wr_data;
  logic        wr_en, done;

  always #10 clk = ~clk;

  svl_vec_seq u_svl_vec_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_vl(cmd_vl), .cmd_subvl(cmd_subvl), .cmd_rd_vec(cmd_rd_vec),
    .cmd_rs1_vec(cmd_rs1_vec), .cmd_rs2_vec(cmd_rs2_vec),
    .cmd_rd_base(cmd_rd_base), .cmd_rs1_base(cmd_rs1_base), .cmd_rs2_base(cmd_rs2_base),
    .cmd_pred_mode(cmd_pred_mode), .cmd_pred_sel(cmd_pred_sel), .cmd_pred_mask(cmd_pred_mask),
    .rs1_addr(rs1_addr), .rs2_addr(rs2_addr), .rs1_data(rs1_data), .rs2_data(rs2_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  // Register file model
  logic [15:0] rf [32];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 32; k++) rf[k] <= 16'(k * 16'h1357 + 16'h0101);
    end else if (wr_en) begin
      rf[wr_addr] <= wr_data;
    end
  end
  assign rs1_data = rf[rs1_addr];
  assign rs2_data = rf[rs2_addr];

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference state
  logic [15:0] ref_rf [32];
  int          ex_addr [64];
  int          ex_data [64];
  int          ex_n, ex_steps, wr_seen;
  bit          mon_on = 1'b0;
  string       cur_req = "R2";

  always @(negedge clk) begin
    if (mon_on && wr_en) begin
      if (wr_seen < ex_n) begin
        chk(int'(wr_addr) == ex_addr[wr_seen], {cur_req, "/R3"}, "write address",
            int'(wr_addr), ex_addr[wr_seen]);
        chk(int'(wr_data) == ex_data[wr_seen], "R8", "write data",
            int'(wr_data), ex_data[wr_seen]);
      end else begin
        chk(1'b0, "R9", "unexpected write", wr_seen + 1, ex_n);
      end
      wr_seen++;
    end
  end

  // Reference loop built from the requirements (R2 R4 R5 R6 R7 R11).
  task automatic build_ref(input int vl, input int subvl, input bit dv, input bit v1,
                           input bit v2, input int bd, input int b1, input int b2,
                           input int mode, input int sel, input int mask);
    int vle, sv, m, id, i1, i2, a1, a2, ad;
    for (int k = 0; k < 32; k++) ref_rf[k] = rf[k];
    vle = (vl > 8) ? 8 : vl;
    sv  = (subvl == 0) ? 1 : ((subvl > 4) ? 4 : subvl);
    if (mode == 1)      m = 255;
    else if (mode == 2) m = 1 << sel;
    else                m = mask & 255;
    m = m & ((1 << vle) - 1);
    ex_n = 0; ex_steps = 0;
    if (m != 0) begin
      id = 0; i1 = 0; i2 = 0;
      for (int i = 0; i < vle; i++) begin
        if (((m >> i) & 1) == 1) begin
          for (int s = 0; s < sv; s++) begin
            a1 = (b1 + i1 * sv + s) % 32;
            a2 = (b2 + i2 * sv + s) % 32;
            ad = (bd + id * sv + s) % 32;
            ref_rf[ad] = 16'(ref_rf[a1] + ref_rf[a2]);
            ex_addr[ex_n] = ad;
            ex_data[ex_n] = int'(ref_rf[ad]);
            ex_n++;
            ex_steps++;
          end
          if (!dv) break;
        end else begin
          ex_steps++;
        end
        if (dv) id++;
        if (v1) i1++;
        if (v2) i2++;
      end
    end
  endtask

  task automatic drive_cmd(input int vl, input int subvl, input bit dv, input bit v1,
                           input bit v2, input int bd, input int b1, input int b2,
                           input int mode, input int sel, input int mask);
    cmd_vl = 4'(vl); cmd_subvl = 3'(subvl);
    cmd_rd_vec = dv; cmd_rs1_vec = v1; cmd_rs2_vec = v2;
    cmd_rd_base = 5'(bd); cmd_rs1_base = 5'(b1); cmd_rs2_base = 5'(b2);
    cmd_pred_mode = 2'(mode); cmd_pred_sel = 3'(sel); cmd_pred_mask = 8'(mask);
    cmd_valid = 1'b1;
  endtask

  task automatic finish_op(input string req);
    int cnt = 0;
    int bad = -1;
    while (!done && cnt < 500) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == ex_steps, {req, "/R10"}, "cycles to done", cnt, ex_steps);
    chk(wr_seen == ex_n, {req, "/R9"}, "write count", wr_seen, ex_n);
    mon_on = 1'b0;
    for (int k = 0; k < 32; k++) if (bad < 0 && rf[k] !== ref_rf[k]) bad = k;
    chk(bad < 0, {req, "/R3"}, "register file mismatch at index",
        bad, -1);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done pulse length", int'(done), 0);
  endtask

  task automatic run_op(input string req, input int vl, input int subvl, input bit dv,
                        input bit v1, input bit v2, input int bd, input int b1,
                        input int b2, input int mode, input int sel, input int mask);
    build_ref(vl, subvl, dv, v1, v2, bd, b1, b2, mode, sel, mask);
    cur_req = req;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "ready when idle", int'(cmd_ready), 1);
    drive_cmd(vl, subvl, dv, v1, v2, bd, b1, b2, mode, sel, mask);
    wr_seen = 0; mon_on = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    finish_op(req);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "reset ready", int'(cmd_ready), 1);
    chk(done == 1'b0, "R1", "reset done", int'(done), 0);
    chk(wr_en == 1'b0, "R1", "reset wr_en", int'(wr_en), 0);

    // Sweep: operand kinds x VL x SUBVL x predicate modes (R2 R4 R6 R7).
    for (int ov = 0; ov < 8; ov++) begin
      for (int vl = 0; vl <= 8; vl++) begin
        for (int sv = 1; sv <= 4; sv++) begin
          string rq;
          rq = ((ov & 1) == 0) ? "R7" : "R4";
          run_op(rq, vl, sv, ov[0], ov[1], ov[2], (ov * 5 + vl) % 32,
                 (vl * 7 + 3) % 32, (sv * 11 + 1) % 32, 1, 0, 0);
          run_op("R6", vl, sv, ov[0], ov[1], ov[2], (ov * 3 + sv) % 32,
                 (vl * 5 + 9) % 32, (sv * 13 + 2) % 32, 2, (vl * 3 + sv) % 8, 0);
          run_op("R5", vl, sv, ov[0], ov[1], ov[2], (ov * 9 + 4) % 32,
                 (vl + sv * 3) % 32, (ov * 7 + 20) % 32, 0, 0, int'($urandom % 256));
        end
      end
    end

    // Boundary cases.
    run_op("R5", 8, 2, 1, 1, 1, 0, 16, 24, 0, 0, 0);          // empty mask
    run_op("R5", 3, 1, 1, 1, 1, 4, 12, 20, 0, 0, 8'hF8);      // only bits above VL
    run_op("R6", 6, 2, 1, 0, 1, 8, 3, 17, 3, 0, 8'h2D);       // mode 3 acts as mask
    run_op("R11", 12, 1, 1, 1, 1, 0, 8, 16, 1, 0, 0);         // VL clamped to 8
    run_op("R11", 3, 0, 1, 1, 1, 2, 9, 21, 1, 0, 0);          // SUBVL 0 -> 1
    run_op("R11", 2, 7, 1, 1, 1, 1, 10, 22, 1, 0, 0);         // SUBVL clamped to 4
    run_op("R7", 5, 3, 0, 1, 1, 30, 6, 14, 0, 0, 8'h1A);      // scalar dest picks elem 1
    run_op("R9", 8, 1, 1, 0, 0, 16, 2, 5, 0, 0, 8'h55);       // skipped elements untouched

    // R12: done of one command coincides with acceptance of the next.
    begin
      int cnt;
      bit seen_both;
      build_ref(4, 1, 1, 1, 1, 10, 0, 20, 1, 0, 0);
      cur_req = "R12";
      @(negedge clk);
      drive_cmd(4, 1, 1, 1, 1, 10, 0, 20, 1, 0, 0);
      wr_seen = 0; mon_on = 1'b1;
      @(posedge clk);
      @(negedge clk);
      drive_cmd(0, 1, 1, 1, 1, 0, 0, 0, 1, 0, 0);
      cnt = 0;
      while (!cmd_ready && cnt < 100) begin
        @(negedge clk);
        cnt++;
      end
      seen_both = done && cmd_ready && cmd_valid;
      chk(seen_both, "R12", "done with accept same cycle", int'(done), 1);
      chk(cnt == ex_steps, "R12", "first command cycles", cnt, ex_steps);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(done == 1'b1, "R12", "second command done", int'(done), 1);
      chk(wr_seen == ex_n, "R12", "write count", wr_seen, ex_n);
      mon_on = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R10", "done clears", int'(done), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule